// File: doc/BRIEF.md
# Prioritized Eight-Source Interrupt Controller

This block takes interrupt requests from eight sources, keeps them in a pending register and presents the most urgent unmasked one to a program sequencer as a vector address. Three of the sources are active-low external request lines. Each line passes through a two-flop synchronizer and can be set to either edge or level sensitivity. Two sources are software-only. The other three are internal active-high request pulses. Software uses a register write port to load the mask, load the control word (sensitivities and nesting enable), and write a 16-bit force/clear word. A set bit in the low byte of that word clears the matching pending bit. A set bit in the high byte forces the matching pending bit.

The vector leaves on a valid/ready stream. Once `vec_valid` is raised, `vec_addr` holds its value until the sequencer accepts it with `vec_ready`. There is no back-pressure limit: an offer can wait for any number of cycles. On acceptance the source moves into the in-service set and its latched pending bit is cleared. A one-cycle `rti` pulse ends service of the highest-priority in-service source. When nesting is off, nothing new is offered while any source is in service. When nesting is on, an offer is made only for a source of higher priority than every in-service source.

Source map (index : origin): 0, 2, 7 : internal pulse on `int_req` at that bit; 1 : external line 2 (peripheral line); 3, 4 : software only; 5 : external line 1; 6 : external line 0. A lower index has higher priority. The vector address is the index times 4.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `pending`, `in_service` and `vec_valid` are all zero. The mask is zero, all three external lines are level sensitive and nesting is off.
- R2: A write with `reg_sel`=2 applies the force/clear word. A 1 in `reg_wdata[i]` (i<8) clears pending bit i, and a 1 in `reg_wdata[8+i]` sets it. When the same bit is both cleared and forced, the force wins. Sources 3 and 4 become pending only through this path; `int_req[3]` and `int_req[4]` are ignored.
- R3: `reg_sel`=0 loads the mask from `reg_wdata[7:0]`, where bit i enables source i. A pending source whose mask bit is 0 is never offered.
- R4: Among the pending, unmasked sources eligible for an offer, the one with the lowest index is offered first, and `vec_addr` = index × 4.
- R5: `reg_sel`=1 loads the control word. Bits 0, 1 and 2 set the sensitivity of external lines 0, 1 and 2 (1 = edge, 0 = level), and bit 4 enables nesting. In edge mode a synchronized falling edge latches the pending bit, which stays set after the line returns high.
- R6: In level mode the source counts as pending while its synchronized line is low and stops once the line is back high; it is not latched.
- R7: With nesting off, no vector is offered while `in_service` is nonzero.
- R8: With nesting on, a vector is offered only for a source whose index is below that of every in-service source.
- R9: An `rti` pulse clears the lowest-index bit of `in_service`.
- R10: While `vec_valid` is high and `vec_ready` is low, `vec_addr` stays stable. A handshake sets the offered source's `in_service` bit and clears its latched pending bit.
- R11: The peripheral line (external line 2) vectors to address 0x04 and requires mask bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_n | input | 3 | Active-low external request lines 0..2 |
| int_req | input | 8 | Internal request pulses; only bits 0, 2 and 7 are used |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 mask, 1 control, 2 force/clear, 3 none |
| reg_wdata | input | 16 | Write data |
| rti | input | 1 | Return-from-interrupt pulse |
| vec_valid | output | 1 | Vector offer valid |
| vec_ready | input | 1 | Sequencer accepts the offer |
| vec_addr | output | 8 | Vector address (index × 4) |
| pending | output | 8 | Latched pending bits |
| in_service | output | 8 | Sources currently being serviced |

## Verification
The assertions assume that `rti` arrives only while some source is in service and at most once per serviced source. They also assume that `vec_ready` may toggle freely but never causes an accept unless `vec_valid` is high. The stimulus pulses `rti` only after the scoreboard has seen the matching handshake. It holds each external line low for at least three cycles so the synchronizer cannot miss it. All inputs change a quarter period after the rising edge, so every sampled value is settled.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int NSRC = 8;
  localparam int NEXT = 3;
  localparam int IDXW = $clog2(NSRC);
  // source index served by each external line 0..2
  localparam int EXT_IDX [NEXT] = '{6, 5, 1};
  // sources fed from int_req
  localparam logic [NSRC-1:0] INT_SRC = 8'b1000_0101;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_FC   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
  localparam int CTRL_NEST_BIT = 4;
endpackage

// File: rtl/icu_line_cond.sv
module icu_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic line_n,
  output logic active,
  output logic fall
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      s1_q   <= line_n;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign active = ~s2_q;
  assign fall   = prev_q & ~s2_q;
endmodule

// File: rtl/icu_prio.sv
module icu_prio #(
  parameter int N = 8,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = W'(i);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import icu_pkg::*;
#(
  parameter int VEC_AW     = 8,
  parameter int VEC_STRIDE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NEXT-1:0]   ext_irq_n,
  input  logic [NSRC-1:0]   int_req,
  input  logic              reg_we,
  input  logic [1:0]        reg_sel,
  input  logic [15:0]       reg_wdata,
  input  logic              rti,
  output logic              vec_valid,
  input  logic              vec_ready,
  output logic [VEC_AW-1:0] vec_addr,
  output logic [NSRC-1:0]   pending,
  output logic [NSRC-1:0]   in_service
);
  localparam logic [VEC_AW-1:0] STRIDE_W = VEC_AW'(VEC_STRIDE);

  logic [NSRC-1:0] pend_q, mask_q, isr_q;
  logic [NEXT-1:0] sens_q;
  logic            nest_q;
  logic            offer_v;
  logic [IDXW-1:0] offer_idx;

  logic [NEXT-1:0] line_act, line_fall;

  for (genvar e = 0; e < NEXT; e++) begin : g_line
    icu_line_cond u_cond (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_n (ext_irq_n[e]),
      .active (line_act[e]),
      .fall   (line_fall[e])
    );
  end

  // hardware set events and level-mode contributions
  logic [NSRC-1:0] hw_set, lvl_act;
  always_comb begin
    hw_set  = int_req & INT_SRC;
    lvl_act = '0;
    for (int e = 0; e < NEXT; e++) begin
      hw_set[EXT_IDX[e]]  = hw_set[EXT_IDX[e]] | (sens_q[e] & line_fall[e]);
      lvl_act[EXT_IDX[e]] = ~sens_q[e] & line_act[e];
    end
  end

  // register writes
  logic            fc_we;
  logic [NSRC-1:0] clr_v, frc_v;
  assign fc_we = reg_we && (reg_sel == SEL_FC);
  assign clr_v = fc_we ? reg_wdata[7:0]  : '0;
  assign frc_v = fc_we ? reg_wdata[15:8] : '0;

  // handshake and return
  logic            take;
  logic [NSRC-1:0] take_oh, rti_oh;
  assign take    = offer_v & vec_ready;
  assign take_oh = take ? (NSRC'(1) << offer_idx) : '0;

  // selection
  logic [NSRC-1:0] cand;
  logic            best_f, top_f, eligible, load;
  logic [IDXW-1:0] best_i, top_i;
  assign cand = (pend_q | lvl_act) & mask_q;

  icu_prio #(.N(NSRC)) u_pick (.req(cand),  .found(best_f), .idx(best_i));
  icu_prio #(.N(NSRC)) u_top  (.req(isr_q), .found(top_f),  .idx(top_i));

  assign eligible = best_f && (!top_f || (nest_q && (best_i < top_i)));
  assign load     = !offer_v && eligible;
  assign rti_oh   = (rti && top_f) ? (NSRC'(1) << top_i) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= '0;
      mask_q    <= '0;
      isr_q     <= '0;
      sens_q    <= '0;
      nest_q    <= 1'b0;
      offer_v   <= 1'b0;
      offer_idx <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_v & ~take_oh) | hw_set | frc_v;
      isr_q  <= (isr_q & ~rti_oh) | take_oh;
      if (reg_we && (reg_sel == SEL_MASK)) mask_q <= reg_wdata[NSRC-1:0];
      if (reg_we && (reg_sel == SEL_CTRL)) begin
        sens_q <= reg_wdata[NEXT-1:0];
        nest_q <= reg_wdata[CTRL_NEST_BIT];
      end
      if (take) begin
        offer_v <= 1'b0;
      end else if (load) begin
        offer_v   <= 1'b1;
        offer_idx <= best_i;
      end
    end
  end

  assign vec_valid  = offer_v;
  assign vec_addr   = VEC_AW'(offer_idx) * STRIDE_W;
  assign pending    = pend_q;
  assign in_service = isr_q;

  // offer held stable under back-pressure
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_addr)));

  // accepted source enters service
  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && vec_ready) |=> in_service[$past(offer_idx)]);

  // without nesting a fresh offer only starts from an idle service set
  p_nonest_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_valid) && !$past(nest_q)) |-> ($past(in_service) == '0));

  // an offer made during service implies nesting was on
  p_nest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vec_valid) && ($past(in_service) != '0)) |-> $past(nest_q));

  // a return removes exactly one in-service bit
  p_rti_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rti && !(vec_valid && vec_ready) && (in_service != '0)) |=>
      ($countones(in_service) + 1 == $countones($past(in_service))));
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_irq_n = 3'b111;
  logic [7:0]  int_req = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        rti = 1'b0;
  logic        vec_ready = 1'b0;
  logic        vec_valid;
  logic [7:0]  vec_addr, pending, in_service;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] expq[$];

  always #(CLK_P/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_irq_n(ext_irq_n), .int_req(int_req),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .rti(rti),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_addr(vec_addr),
    .pending(pending), .in_service(in_service)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    tick();
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic do_rti();
    tick();
    rti = 1'b1;
    tick();
    rti = 1'b0;
  endtask

  task automatic expect_vec(input logic [7:0] a);
    expq.push_back(a);
  endtask

  task automatic drain(input string tag);
    int t = 0;
    while (expq.size() != 0 && t < 200) begin
      @(negedge clk);
      t++;
    end
    chk(tag, expq.size(), 0);
    tick();
  endtask

  // scoreboard monitor: one compare per handshake
  always @(negedge clk) begin
    if (rst_n && vec_valid && vec_ready) begin
      if (expq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R4 unexpected vector actual=%h expected=none", vec_addr);
      end else begin
        chk("R4 vector order/address", vec_addr, expq.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pending", pending, 8'h00);
    chk("R1 in_service", in_service, 8'h00);
    chk("R1 vec_valid", vec_valid, 0);

    // R2/R4/R10/R7/R9: forced sources served in priority order
    wr(0, 16'h00FF);
    wr(2, 16'h8900);
    @(negedge clk);
    chk("R2 force pending", pending, 8'h89);
    @(negedge clk); @(negedge clk);
    chk("R4 first offer valid", vec_valid, 1);
    chk("R4 first offer addr", vec_addr, 8'h00);
    @(negedge clk);
    chk("R10 held under back-pressure", vec_addr, 8'h00);
    expect_vec(8'h00);
    vec_ready = 1'b1;
    drain("R4 drain idx0");
    @(negedge clk);
    chk("R10 in_service after accept", in_service, 8'h01);
    chk("R10 pending cleared on accept", pending, 8'h88);
    repeat (4) tick();
    @(negedge clk);
    chk("R7 no offer while in service", vec_valid, 0);
    expect_vec(8'h0C);
    do_rti();
    drain("R4 drain idx3");
    expect_vec(8'h1C);
    do_rti();
    drain("R4 drain idx7");
    do_rti();
    @(negedge clk);
    chk("R9 service set empty", in_service, 8'h00);
    chk("R9 pending empty", pending, 8'h00);

    // R3/R2: masking, clearing, force over clear, software-only sources
    wr(0, 16'h0000);
    wr(2, 16'h0400);
    repeat (3) tick();
    @(negedge clk);
    chk("R3 masked not offered", vec_valid, 0);
    chk("R3 masked stays pending", pending, 8'h04);
    wr(2, 16'h0004);
    @(negedge clk);
    chk("R2 clear low byte", pending, 8'h00);
    wr(2, 16'h1010);
    @(negedge clk);
    chk("R2 force beats clear", pending, 8'h10);
    wr(2, 16'h0010);
    tick(); int_req = 8'h18; tick(); int_req = 8'h00;
    @(negedge clk);
    chk("R2 sw sources ignore int_req", pending, 8'h00);
    tick(); int_req = 8'h01; tick(); int_req = 8'h00;
    @(negedge clk);
    chk("R2 internal pulse latched", pending, 8'h01);
    wr(2, 16'h0001);

    // R5: edge mode on external line 0 (source 6)
    wr(1, 16'h0001);
    tick(); ext_irq_n[0] = 1'b0;
    repeat (3) tick();
    ext_irq_n[0] = 1'b1;
    repeat (5) tick();
    @(negedge clk);
    chk("R5 edge latched", pending, 8'h40);
    wr(2, 16'h0040);

    // R6: level mode on external line 1 (source 5), unmasked
    wr(1, 16'h0000);
    wr(0, 16'h0020);
    vec_ready = 1'b0;
    tick(); ext_irq_n[1] = 1'b0;
    repeat (4) tick();
    @(negedge clk);
    chk("R6 level follows line (offer)", vec_valid, 1);
    chk("R6 level not latched in pending", pending, 8'h00);
    tick(); ext_irq_n[1] = 1'b1;
    expect_vec(8'h14);
    vec_ready = 1'b1;
    drain("R6 drain idx5");
    do_rti();
    repeat (4) tick();
    @(negedge clk);
    chk("R6 line high no new offer", vec_valid, 0);

    // R11: peripheral line 2 level request
    wr(0, 16'h0002);
    expect_vec(8'h04);
    tick(); ext_irq_n[2] = 1'b0;
    drain("R11 drain peripheral");
    @(negedge clk);
    chk("R11 in service", in_service, 8'h02);
    tick(); ext_irq_n[2] = 1'b1;
    repeat (5) tick();
    do_rti();
    repeat (3) tick();
    @(negedge clk);
    chk("R11 released", vec_valid, 0);
    chk("R11 service empty", in_service, 8'h00);

    // R8/R9: nesting
    wr(0, 16'h00FF);
    wr(1, 16'h0010);
    expect_vec(8'h14);
    wr(2, 16'h2000);
    drain("R8 drain idx5");
    wr(2, 16'h4000);
    repeat (4) tick();
    @(negedge clk);
    chk("R8 lower priority waits", vec_valid, 0);
    chk("R8 lower priority pending", pending, 8'h40);
    expect_vec(8'h08);
    wr(2, 16'h0400);
    drain("R8 drain idx2");
    @(negedge clk);
    chk("R8 nested service set", in_service, 8'h24);
    do_rti();
    @(negedge clk);
    chk("R9 rti clears top only", in_service, 8'h20);
    expect_vec(8'h18);
    do_rti();
    drain("R8 drain idx6");
    @(negedge clk);
    chk("R8 resumed lower source", in_service, 8'h40);
    do_rti();
    @(negedge clk);
    chk("R9 all returned", in_service, 8'h00);
    chk("R4 scoreboard empty", expq.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule